// File: doc/BRIEF.md
# Three-Port Parallel Register Interface

This block sits between a processor's register bus and three 8-bit parallel ports, named A, B and C. Each port holds an output latch and drives an output-enable. The processor reads and writes the ports and a control register through a 2-bit address, using a write strobe and a read strobe that are both sampled on the rising clock edge. Ports A and B each take one direction for all eight bits. Port C is split into a lower and an upper nibble, and each nibble has its own direction. No handshake lines are used.

A control-register write carries one of two kinds of word. The kind is chosen by bit 7. A configuration word sets the four direction fields and clears every output latch. A single-bit word forces one chosen port C latch bit to 0 or 1 and leaves the other seven bits unchanged. Reads are combinational. An output-configured slice returns its latch and an input-configured slice returns its pins.

Top module: `ppi_core`

## Requirements
- R1: While rst_n is low, every output-enable is 0, so all ports are inputs, and every output latch is 0.
- R2: Address 0 is port A, address 1 is port B, address 2 is port C and address 3 is the control register. A write to addresses 0 to 2 loads wdata into that port's latch, and the new value appears on the matching *_out in the cycle after the write edge.
- R3: A control write with wdata[7]=1 is a configuration word. Bit 4 sets the direction of port A, bit 3 the upper nibble of port C, bit 1 port B and bit 0 the lower nibble of port C. A 1 means input (output-enable 0) and a 0 means output (output-enable 1).
- R4: A configuration word clears the port A, B and C latches to 0 on the same edge that loads the new directions.
- R5: A control write with wdata[7]=0 is a single-bit word. wdata[3:1] selects the port C bit and wdata[0] is its new value. The other port C bits, the A and B latches and all directions stay unchanged.
- R6: While rd_en is 1, rdata returns the latch for every bit whose slice is an output and returns the pins for every bit whose slice is an input.
- R7: A write to an input-configured port leaves its output-enable at 0, and reads of that port keep returning the pins.
- R8: rdata is 0 when rd_en is 0, and it is 0 for a read of address 3.
- R9: When wr_en is 0, the latches and the directions keep their values whatever addr and wdata carry.
- R10: The two port C nibbles take their directions independently. In a mixed setting, one read returns pins in one nibble and latch bits in the other.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 2 | Register select |
| wr_en | input | 1 | Write strobe, acts on the rising edge |
| rd_en | input | 1 | Read strobe, gates rdata |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data (combinational) |
| pa_in | input | 8 | Port A pins |
| pa_out | output | 8 | Port A latch |
| pa_oe | output | 1 | Port A output-enable |
| pb_in | input | 8 | Port B pins |
| pb_out | output | 8 | Port B latch |
| pb_oe | output | 1 | Port B output-enable |
| pc_in | input | 8 | Port C pins |
| pc_out | output | 8 | Port C latch |
| pc_oe | output | 8 | Port C per-bit output-enable (uniform within each nibble) |

## Verification
The properties assume that addr, wdata and the two strobes are synchronous to clk and settle before each rising edge. Their comparisons look one cycle back with $past, so they only make sense if the sampled values are clean. The read-data properties also assume that the pin inputs are stable while a read is sampled. The bench meets these assumptions by changing every input only on the falling edge. It holds the pins at fixed patterns across each read and raises each strobe for exactly one cycle.

// File: rtl/ppi_pkg.sv
`timescale 1ns/1ps
package ppi_pkg;
    localparam int PORT_W    = 8;
    localparam int ADDR_W    = 2;
    localparam int C_GROUPS  = 2;
    localparam int C_SLICE_W = PORT_W / C_GROUPS;
    localparam int BIT_SEL_W = $clog2(PORT_W);

    localparam logic [ADDR_W-1:0] ADDR_PA   = 2'd0;
    localparam logic [ADDR_W-1:0] ADDR_PB   = 2'd1;
    localparam logic [ADDR_W-1:0] ADDR_PC   = 2'd2;
    localparam logic [ADDR_W-1:0] ADDR_CTRL = 2'd3;

    // control word field positions
    localparam int CW_KIND    = 7;
    localparam int CW_DIR_A   = 4;
    localparam int CW_DIR_CHI = 3;
    localparam int CW_DIR_B   = 1;
    localparam int CW_DIR_CLO = 0;
    localparam int CW_SEL_LSB = 1;
    localparam int CW_VAL     = 0;

    typedef enum logic [2:0] {
        ACC_NONE,
        ACC_LOAD_A,
        ACC_LOAD_B,
        ACC_LOAD_C,
        ACC_MODE_SET,
        ACC_BIT_SR
    } acc_kind_t;
endpackage

// File: rtl/ppi_access_decode.sv
`timescale 1ns/1ps
module ppi_access_decode
    import ppi_pkg::*;
(
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic              kind_bit,
    output acc_kind_t         kind
);
    always_comb begin
        kind = ACC_NONE;
        if (wr_en) begin
            unique case (addr)
                ADDR_PA:   kind = ACC_LOAD_A;
                ADDR_PB:   kind = ACC_LOAD_B;
                ADDR_PC:   kind = ACC_LOAD_C;
                ADDR_CTRL: kind = kind_bit ? ACC_MODE_SET : ACC_BIT_SR;
                default:   kind = ACC_NONE;
            endcase
        end
    end
endmodule

// File: rtl/ppi_port_reg.sv
`timescale 1ns/1ps
module ppi_port_reg #(
    parameter int W      = 8,
    parameter int GROUPS = 1,
    parameter int SEL_W  = $clog2(W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_en,
    input  logic [W-1:0]      load_val,
    input  logic              clear_en,
    input  logic              dir_en,
    input  logic [GROUPS-1:0] dir_is_in,
    input  logic              bit_en,
    input  logic [SEL_W-1:0]  bit_sel,
    input  logic              bit_val,
    input  logic [W-1:0]      pins,
    output logic [W-1:0]      latch_q,
    output logic [GROUPS-1:0] grp_oe,
    output logic [W-1:0]      rd_val
);
    localparam int SLICE = W / GROUPS;

    logic [GROUPS-1:0] is_input;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            latch_q  <= '0;
            is_input <= '1;
        end else begin
            if (clear_en)
                latch_q <= '0;
            else if (load_en)
                latch_q <= load_val;
            else if (bit_en)
                latch_q[bit_sel] <= bit_val;
            if (dir_en)
                is_input <= dir_is_in;
        end
    end

    for (genvar g = 0; g < GROUPS; g++) begin : g_slice
        assign grp_oe[g] = ~is_input[g];
        assign rd_val[g*SLICE +: SLICE] = is_input[g] ? pins[g*SLICE +: SLICE]
                                                      : latch_q[g*SLICE +: SLICE];
    end
endmodule

// File: rtl/ppi_core.sv
`timescale 1ns/1ps
module ppi_core
    import ppi_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [PORT_W-1:0] wdata,
    output logic [PORT_W-1:0] rdata,
    input  logic [PORT_W-1:0] pa_in,
    output logic [PORT_W-1:0] pa_out,
    output logic              pa_oe,
    input  logic [PORT_W-1:0] pb_in,
    output logic [PORT_W-1:0] pb_out,
    output logic              pb_oe,
    input  logic [PORT_W-1:0] pc_in,
    output logic [PORT_W-1:0] pc_out,
    output logic [PORT_W-1:0] pc_oe
);
    acc_kind_t kind;
    logic [PORT_W-1:0] rd_a, rd_b, rd_c;
    logic [C_GROUPS-1:0] c_grp_oe;
    logic mode_set, bit_sr;

    ppi_access_decode u_dec (
        .wr_en    (wr_en),
        .addr     (addr),
        .kind_bit (wdata[CW_KIND]),
        .kind     (kind)
    );

    assign mode_set = (kind == ACC_MODE_SET);
    assign bit_sr   = (kind == ACC_BIT_SR);

    ppi_port_reg #(.W(PORT_W), .GROUPS(1), .SEL_W(BIT_SEL_W)) u_port_a (
        .clk(clk), .rst_n(rst_n),
        .load_en(kind == ACC_LOAD_A), .load_val(wdata),
        .clear_en(mode_set), .dir_en(mode_set),
        .dir_is_in(wdata[CW_DIR_A]),
        .bit_en(1'b0), .bit_sel('0), .bit_val(1'b0),
        .pins(pa_in), .latch_q(pa_out), .grp_oe(pa_oe), .rd_val(rd_a)
    );

    ppi_port_reg #(.W(PORT_W), .GROUPS(1), .SEL_W(BIT_SEL_W)) u_port_b (
        .clk(clk), .rst_n(rst_n),
        .load_en(kind == ACC_LOAD_B), .load_val(wdata),
        .clear_en(mode_set), .dir_en(mode_set),
        .dir_is_in(wdata[CW_DIR_B]),
        .bit_en(1'b0), .bit_sel('0), .bit_val(1'b0),
        .pins(pb_in), .latch_q(pb_out), .grp_oe(pb_oe), .rd_val(rd_b)
    );

    ppi_port_reg #(.W(PORT_W), .GROUPS(C_GROUPS), .SEL_W(BIT_SEL_W)) u_port_c (
        .clk(clk), .rst_n(rst_n),
        .load_en(kind == ACC_LOAD_C), .load_val(wdata),
        .clear_en(mode_set), .dir_en(mode_set),
        .dir_is_in({wdata[CW_DIR_CHI], wdata[CW_DIR_CLO]}),
        .bit_en(bit_sr), .bit_sel(wdata[CW_SEL_LSB +: BIT_SEL_W]),
        .bit_val(wdata[CW_VAL]),
        .pins(pc_in), .latch_q(pc_out), .grp_oe(c_grp_oe), .rd_val(rd_c)
    );

    for (genvar g = 0; g < C_GROUPS; g++) begin : g_c_oe
        assign pc_oe[g*C_SLICE_W +: C_SLICE_W] = {C_SLICE_W{c_grp_oe[g]}};
    end

    always_comb begin
        rdata = '0;
        if (rd_en) begin
            unique case (addr)
                ADDR_PA:   rdata = rd_a;
                ADDR_PB:   rdata = rd_b;
                ADDR_PC:   rdata = rd_c;
                ADDR_CTRL: rdata = '0;
                default:   rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/ppi_core_checker.sv
`timescale 1ns/1ps
module ppi_core_checker
    import ppi_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] addr,
    input logic              wr_en,
    input logic              rd_en,
    input logic [PORT_W-1:0] wdata,
    input logic [PORT_W-1:0] rdata,
    input logic [PORT_W-1:0] pa_in,
    input logic [PORT_W-1:0] pa_out,
    input logic              pa_oe,
    input logic [PORT_W-1:0] pb_in,
    input logic [PORT_W-1:0] pb_out,
    input logic              pb_oe,
    input logic [PORT_W-1:0] pc_in,
    input logic [PORT_W-1:0] pc_out,
    input logic [PORT_W-1:0] pc_oe
);
    logic mode_wr, bit_wr;
    assign mode_wr = wr_en && (addr == ADDR_CTRL) && wdata[CW_KIND];
    assign bit_wr  = wr_en && (addr == ADDR_CTRL) && !wdata[CW_KIND];

    p_reset_inputs_r1: assert property (@(posedge clk)
        !rst_n |=> (!pa_oe && !pb_oe && pc_oe == '0 && pa_out == '0 && pb_out == '0 && pc_out == '0));

    p_port_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADDR_PA) |=> pa_out == $past(wdata));

    p_mode_dirs_r3: assert property (@(posedge clk) disable iff (!rst_n)
        mode_wr |=> (pa_oe == !$past(wdata[CW_DIR_A]) && pb_oe == !$past(wdata[CW_DIR_B])
                     && pc_oe[PORT_W-1] == !$past(wdata[CW_DIR_CHI])
                     && pc_oe[0] == !$past(wdata[CW_DIR_CLO])));

    p_mode_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mode_wr |=> (pa_out == '0 && pb_out == '0 && pc_out == '0));

    p_bit_only_r5: assert property (@(posedge clk) disable iff (!rst_n)
        bit_wr |=> (pc_out[$past(wdata[CW_SEL_LSB +: BIT_SEL_W])] == $past(wdata[CW_VAL])
                    && ((pc_out ^ $past(pc_out)) & ~(PORT_W'(1) << $past(wdata[CW_SEL_LSB +: BIT_SEL_W]))) == '0
                    && $stable(pc_oe) && $stable(pa_out) && $stable(pb_out)));

    p_read_mux_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == ADDR_PC) |-> rdata == ((pc_oe & pc_out) | (~pc_oe & pc_in)));

    p_read_ab_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == ADDR_PB) |-> rdata == (pb_oe ? pb_out : pb_in));

    p_read_a_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == ADDR_PA && !pa_oe) |-> rdata == pa_in);

    p_rdata_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_en || addr == ADDR_CTRL) |-> rdata == '0);

    p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> ($stable(pa_out) && $stable(pb_out) && $stable(pc_out)
                    && $stable(pa_oe) && $stable(pb_oe) && $stable(pc_oe)));

    p_nibble_uniform_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(pc_oe[C_SLICE_W-1:0]) % C_SLICE_W == 0)
        && ($countones(pc_oe[PORT_W-1:C_SLICE_W]) % C_SLICE_W == 0));
endmodule

bind ppi_core ppi_core_checker u_chk (.*);

// File: tb/ppi_core_bench.sv
`timescale 1ns/1ps
module ppi_core_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] addr = '0;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic [7:0] pa_in = '0, pb_in = '0, pc_in = '0;
    logic [7:0] pa_out, pb_out, pc_out, pc_oe;
    logic       pa_oe, pb_oe;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    ppi_core u_ppi_core (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
        .wdata(wdata), .rdata(rdata),
        .pa_in(pa_in), .pa_out(pa_out), .pa_oe(pa_oe),
        .pb_in(pb_in), .pb_out(pb_out), .pb_oe(pb_oe),
        .pc_in(pc_in), .pc_out(pc_out), .pc_oe(pc_oe)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        #1 d = rdata;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic t_reset;
        logic [7:0] d;
        check("R1 pa_oe", {7'd0, pa_oe}, 8'h00);
        check("R1 pb_oe", {7'd0, pb_oe}, 8'h00);
        check("R1 pc_oe", pc_oe, 8'h00);
        check("R1 latches", pa_out | pb_out | pc_out, 8'h00);
        pa_in = 8'h5A;
        bus_read(2'd0, d);
        check("R6 read input A after reset", d, 8'h5A);
    endtask

    task automatic t_all_output;
        logic [7:0] d;
        bus_write(2'd3, 8'h80);
        check("R3 pa_oe", {7'd0, pa_oe}, 8'h01);
        check("R3 pb_oe", {7'd0, pb_oe}, 8'h01);
        check("R3 pc_oe", pc_oe, 8'hFF);
        bus_write(2'd0, 8'h3C);
        bus_write(2'd1, 8'hC3);
        bus_write(2'd2, 8'h81);
        check("R2 pa_out", pa_out, 8'h3C);
        check("R2 pb_out", pb_out, 8'hC3);
        check("R2 pc_out", pc_out, 8'h81);
        pb_in = 8'hFF;
        bus_read(2'd1, d);
        check("R6 read output B", d, 8'hC3);
    endtask

    task automatic t_mode_clear;
        bus_write(2'd3, 8'h80);
        check("R4 pa cleared", pa_out, 8'h00);
        check("R4 pb cleared", pb_out, 8'h00);
        check("R4 pc cleared", pc_out, 8'h00);
    endtask

    task automatic t_bit_sr;
        bus_write(2'd0, 8'h66);
        bus_write(2'd3, 8'h0F);
        check("R5 set bit7", pc_out, 8'h80);
        bus_write(2'd3, 8'h01);
        check("R5 set bit0", pc_out, 8'h81);
        bus_write(2'd3, 8'h0B);
        check("R5 set bit5", pc_out, 8'hA1);
        bus_write(2'd3, 8'h0E);
        check("R5 clear bit7", pc_out, 8'h21);
        check("R5 dirs kept", pc_oe, 8'hFF);
        check("R5 A kept", pa_out, 8'h66);
    endtask

    task automatic t_split_c;
        logic [7:0] d;
        bus_write(2'd3, 8'h88);
        check("R10 pc_oe split", pc_oe, 8'h0F);
        bus_write(2'd2, 8'hA5);
        pc_in = 8'h3C;
        bus_read(2'd2, d);
        check("R10 mixed read C", d, 8'h35);
    endtask

    task automatic t_input_write;
        logic [7:0] d;
        bus_write(2'd3, 8'h93);
        check("R3 pc_oe upper out", pc_oe, 8'hF0);
        bus_write(2'd0, 8'h77);
        check("R7 pa_oe stays 0", {7'd0, pa_oe}, 8'h00);
        pa_in = 8'h12;
        bus_read(2'd0, d);
        check("R7 read pins A", d, 8'h12);
        pb_in = 8'h9E;
        bus_read(2'd1, d);
        check("R6 read pins B", d, 8'h9E);
    endtask

    task automatic t_idle;
        logic [7:0] d;
        bus_write(2'd3, 8'h80);
        bus_write(2'd0, 8'h11);
        @(negedge clk);
        addr = 2'd0; wdata = 8'hFF; wr_en = 1'b0;
        #1 check("R8 rdata idle", rdata, 8'h00);
        @(negedge clk);
        addr = 2'd3; wdata = 8'h9B;
        @(negedge clk);
        check("R9 pa_out held", pa_out, 8'h11);
        check("R9 pc_oe held", pc_oe, 8'hFF);
        bus_read(2'd3, d);
        check("R8 read ctrl", d, 8'h00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_all_output();
        t_mode_clear();
        t_bit_sr();
        t_split_c();
        t_input_write();
        t_idle();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule